// File: doc/BRIEF.md
# Clock Tree Frequency Calculator

This block works out the nominal frequencies, in hertz, of a chip's core clock, its high-speed bus clock and its peripheral clock from the clock-control register settings. It does not toggle any clock. It turns register values into numbers that timers and baud-rate logic can use. A start strobe latches the mode register, the divider register and an already computed PLL output frequency. From the mode register the block picks the PLL reference frequency, then decides whether the core clock uses the PLL output or bypasses the PLL.

Two integer divisions follow in sequence on a single restoring divider that produces one quotient bit per cycle. The first division gives the high-speed frequency and the second gives the peripheral frequency. When both are finished, all results update together and a done flag rises. A combinational query port returns one frequency selected by a clock identifier.

Top module: `clk_freq_calc`

## Requirements
- R1: After reset, every frequency output is 0 and `done` is low.
- R2: The reference frequency is 33554432 (32768 x 1024) when mode bits [2:1] equal 2, and 26000000 for any other value of those bits.
- R3: The core frequency equals the reference frequency when mode bit 7 is set or mode bit 3 is clear; otherwise it equals the PLL frequency input.
- R4: The high-speed frequency is the core frequency divided by (1 + divider bits [13:11]), truncated.
- R5: The peripheral frequency is the high-speed frequency divided by (1 + divider bits [7:6]), truncated.
- R6: A start accepted while idle clears `done`, and the frequency outputs keep their previous values until `done` rises again with the new results.
- R7: A start that arrives while a computation is running has no effect: the running result is the one delivered, and the inputs present with the ignored start are never used.
- R8: The query output is 0 for ID 0, the core frequency for ID 1, the high-speed frequency for ID 2, the peripheral frequency for ID 3, 32768 for ID 4, and 0 for IDs 5 to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a computation; sampled only while idle |
| modeReg | input | 32 | Mode register: reference select [2:1], PLL enable [3], mode select [7] |
| divReg | input | 32 | Divider register: high-speed field [13:11], peripheral field [7:6] |
| pllFreq | input | 32 | Computed PLL output frequency in Hz |
| queryId | input | 3 | Clock identifier for the query port |
| refFreq | output | 32 | PLL reference frequency in Hz |
| coreFreq | output | 32 | Core clock frequency in Hz |
| hsFreq | output | 32 | High-speed clock frequency in Hz |
| perFreq | output | 32 | Peripheral clock frequency in Hz |
| done | output | 1 | High once the latest results are valid |
| queryFreq | output | 32 | Frequency selected by `queryId` |

## Verification
The assertions assume that `start` is only meaningful as a single-cycle request. They also assume that the register inputs need to be valid only in the cycle where a start is accepted, because the block latches them there. The ordering checks rely on each divisor being at least one, which the (field + 1) form always gives. The stimulus holds the inputs steady around each accepted start and changes them together with a second start in mid-computation. It uses register values with extreme divider fields, an all-ones PLL frequency and unrelated bits set, and it never pulses reset while a computation is running.

// File: rtl/clk_freq_pkg.sv
package clk_freq_pkg;
  localparam int unsigned FREQ_W     = 32;
  localparam int unsigned REG_W      = 32;
  localparam logic [FREQ_W-1:0] HIGH_XTAL = 32'd26000000;
  localparam logic [FREQ_W-1:0] LOW_XTAL  = 32'd32768;
  localparam int unsigned LOW_MULT_SH = 10;

  localparam int unsigned REFSEL_LO = 1;
  localparam int unsigned PLLEN_BIT = 3;
  localparam int unsigned MSEL_BIT  = 7;
  localparam int unsigned HSDIV_LO  = 11;
  localparam int unsigned HSDIV_W   = 3;
  localparam int unsigned PERDIV_LO = 6;
  localparam int unsigned PERDIV_W  = 2;

  typedef enum logic [2:0] {
    CLK_NONE = 3'd0,
    CLK_CORE = 3'd1,
    CLK_HS   = 3'd2,
    CLK_PER  = 3'd3,
    CLK_LOW  = 3'd4
  } clk_id_e;

  typedef struct packed {
    logic load1;
    logic load2;
    logic step;
    logic commit;
  } calc_cmd_t;
endpackage

// File: rtl/clk_freq_ctrl.sv
module clk_freq_ctrl
  import clk_freq_pkg::*;
#(
  parameter int unsigned STEPS = FREQ_W
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  output calc_cmd_t cmd,
  output logic      done
);
  localparam int unsigned CNT_W = $clog2(STEPS + 1);

  typedef enum logic [2:0] {S_IDLE, S_RUN1, S_LOAD2, S_RUN2, S_FIN} state_e;

  state_e stateQ, stateD;
  logic [CNT_W-1:0] cntQ;
  logic lastStep;

  assign lastStep = (cntQ == CNT_W'(STEPS - 1));

  always_comb begin
    stateD = stateQ;
    cmd    = '0;
    unique case (stateQ)
      S_IDLE: if (start) begin
        cmd.load1 = 1'b1;
        stateD    = S_RUN1;
      end
      S_RUN1: begin
        cmd.step = 1'b1;
        if (lastStep) stateD = S_LOAD2;
      end
      S_LOAD2: begin
        cmd.load2 = 1'b1;
        stateD    = S_RUN2;
      end
      S_RUN2: begin
        cmd.step = 1'b1;
        if (lastStep) stateD = S_FIN;
      end
      S_FIN: begin
        cmd.commit = 1'b1;
        stateD     = S_IDLE;
      end
      default: stateD = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= S_IDLE;
      cntQ   <= '0;
      done   <= 1'b0;
    end else begin
      stateQ <= stateD;
      if (cmd.step && !lastStep) cntQ <= cntQ + 1'b1;
      else                       cntQ <= '0;
      if (cmd.load1)       done <= 1'b0;
      else if (cmd.commit) done <= 1'b1;
    end
  end

  // R6: an accepted start drops done on the next cycle
  p_done_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == S_IDLE && start) |=> !done);

  // R7: a start while busy never returns the machine to a fresh load
  p_busy_ignore_r7: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ != S_IDLE && start) |-> !cmd.load1);

  // at most one command strobe at a time
  p_one_cmd_r6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cmd.load1, cmd.load2, cmd.step, cmd.commit}));
endmodule

// File: rtl/clk_freq_dp.sv
module clk_freq_dp
  import clk_freq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  calc_cmd_t         cmd,
  input  logic [REG_W-1:0]  modeReg,
  input  logic [REG_W-1:0]  divReg,
  input  logic [FREQ_W-1:0] pllFreq,
  output logic [FREQ_W-1:0] refFreq,
  output logic [FREQ_W-1:0] coreFreq,
  output logic [FREQ_W-1:0] hsFreq,
  output logic [FREQ_W-1:0] perFreq
);
  localparam logic [FREQ_W-1:0] LOW_REF = LOW_XTAL << LOW_MULT_SH;

  logic [1:0]        refSel;
  logic              bypass;
  logic [FREQ_W-1:0] refNew, coreNew;
  logic [FREQ_W-1:0] refW, coreW, hsW;
  logic [FREQ_W-1:0] quoQ, remQ, dvsrQ;
  logic [FREQ_W-1:0] perDvsrQ;
  logic [FREQ_W:0]   shifted, trial;
  logic              fits;

  assign refSel  = modeReg[REFSEL_LO +: 2];
  assign bypass  = modeReg[MSEL_BIT] || !modeReg[PLLEN_BIT];
  assign refNew  = (refSel == 2'd2) ? LOW_REF : HIGH_XTAL;
  assign coreNew = bypass ? refNew : pllFreq;

  assign shifted = {remQ, quoQ[FREQ_W-1]};
  assign trial   = shifted - {1'b0, dvsrQ};
  assign fits    = !trial[FREQ_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refW <= '0; coreW <= '0; hsW <= '0;
      quoQ <= '0; remQ <= '0; dvsrQ <= '0; perDvsrQ <= '0;
      refFreq <= '0; coreFreq <= '0; hsFreq <= '0; perFreq <= '0;
    end else begin
      if (cmd.load1) begin
        refW     <= refNew;
        coreW    <= coreNew;
        quoQ     <= coreNew;
        remQ     <= '0;
        dvsrQ    <= FREQ_W'(divReg[HSDIV_LO +: HSDIV_W]) + 1'b1;
        perDvsrQ <= FREQ_W'(divReg[PERDIV_LO +: PERDIV_W]) + 1'b1;
      end
      if (cmd.step) begin
        remQ <= fits ? trial[FREQ_W-1:0] : shifted[FREQ_W-1:0];
        quoQ <= {quoQ[FREQ_W-2:0], fits};
      end
      if (cmd.load2) begin
        hsW   <= quoQ;
        quoQ  <= quoQ;
        remQ  <= '0;
        dvsrQ <= perDvsrQ;
      end
      if (cmd.commit) begin
        refFreq  <= refW;
        coreFreq <= coreW;
        hsFreq   <= hsW;
        perFreq  <= quoQ;
      end
    end
  end

  // R6: results move only on a commit strobe from the control
  p_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !cmd.commit |=> ($stable(coreFreq) && $stable(hsFreq) && $stable(perFreq)
                     && $stable(refFreq)));

  // R4: a divisor of at least one never lets the quotient exceed the dividend
  p_hs_le_core_r4: assert property (@(posedge clk) disable iff (!rstN)
    cmd.commit |=> (hsFreq <= coreFreq));

  // R5: the second stage never exceeds the first
  p_per_le_hs_r5: assert property (@(posedge clk) disable iff (!rstN)
    cmd.commit |=> (perFreq <= hsFreq));
endmodule

// File: rtl/clk_freq_calc.sv
module clk_freq_calc
  import clk_freq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [31:0] modeReg,
  input  logic [31:0] divReg,
  input  logic [31:0] pllFreq,
  input  logic [2:0]  queryId,
  output logic [31:0] refFreq,
  output logic [31:0] coreFreq,
  output logic [31:0] hsFreq,
  output logic [31:0] perFreq,
  output logic        done,
  output logic [31:0] queryFreq
);
  calc_cmd_t cmd;

  clk_freq_ctrl #(.STEPS(FREQ_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .cmd(cmd), .done(done)
  );

  clk_freq_dp u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd),
    .modeReg(modeReg), .divReg(divReg), .pllFreq(pllFreq),
    .refFreq(refFreq), .coreFreq(coreFreq), .hsFreq(hsFreq), .perFreq(perFreq)
  );

  always_comb begin
    unique case (queryId)
      CLK_CORE: queryFreq = coreFreq;
      CLK_HS:   queryFreq = hsFreq;
      CLK_PER:  queryFreq = perFreq;
      CLK_LOW:  queryFreq = LOW_XTAL;
      default:  queryFreq = '0;
    endcase
  end
endmodule

// File: tb/clk_freq_calc_bench.sv
module clk_freq_calc_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [31:0] modeReg = '0, divReg = '0, pllFreq = '0;
  logic [2:0]  queryId = '0;
  logic [31:0] refFreq, coreFreq, hsFreq, perFreq, queryFreq;
  logic        done;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [31:0] ref_;
    logic [31:0] core;
    logic [31:0] hs;
    logic [31:0] per;
  } exp_t;
  exp_t expQ[$];

  always #4 clk = ~clk;

  clk_freq_calc u_clk_freq_calc (
    .clk(clk), .rstN(rstN), .start(start), .modeReg(modeReg), .divReg(divReg),
    .pllFreq(pllFreq), .queryId(queryId), .refFreq(refFreq), .coreFreq(coreFreq),
    .hsFreq(hsFreq), .perFreq(perFreq), .done(done), .queryFreq(queryFreq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic exp_t model(logic [31:0] m, logic [31:0] d, logic [31:0] p);
    exp_t e;
    e.ref_ = (m[2:1] == 2'd2) ? 32'd33554432 : 32'd26000000;
    e.core = (m[7] || !m[3]) ? e.ref_ : p;
    e.hs   = e.core / ({29'd0, d[13:11]} + 32'd1);
    e.per  = e.hs / ({30'd0, d[7:6]} + 32'd1);
    return e;
  endfunction

  // driver: push expectation, request, optionally probe mid-run
  task automatic drive(logic [31:0] m, logic [31:0] d, logic [31:0] p, bit probe);
    logic [31:0] oldCore;
    @(negedge clk);
    oldCore = coreFreq;
    expQ.push_back(model(m, d, p));
    modeReg = m; divReg = d; pllFreq = p; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    modeReg = '0; divReg = '0; pllFreq = '0;
    if (probe) begin
      repeat (3) @(negedge clk);
      check("R6 done low while busy", {31'd0, done}, 32'd0);
      check("R6 core held while busy", coreFreq, oldCore);
      // R7: second request with different settings during the run
      modeReg = 32'h0000_0004; divReg = 32'h0000_38C0; pllFreq = 32'd1; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      modeReg = '0; divReg = '0; pllFreq = '0;
    end
    wait (expQ.size() == 0);
    repeat (2) @(negedge clk);
  endtask

  // monitor: compare each delivered result against the queue
  initial begin
    forever begin
      @(posedge done);
      @(negedge clk);
      if (expQ.size() == 0) begin
        check("R7 unexpected result", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = expQ[0];
        check("R2 reference", refFreq, e.ref_);
        check("R3 core", coreFreq, e.core);
        check("R4 high-speed", hsFreq, e.hs);
        check("R5 peripheral", perFreq, e.per);
        for (int i = 0; i < 8; i++) begin
          logic [31:0] q;
          queryId = 3'(i);
          #1;
          case (i)
            1: q = e.core;
            2: q = e.hs;
            3: q = e.per;
            4: q = 32'd32768;
            default: q = 32'd0;
          endcase
          check("R8 query", queryFreq, q);
        end
        queryId = '0;
        void'(expQ.pop_front());
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 core at reset", coreFreq, 32'd0);
    check("R1 ref at reset", refFreq, 32'd0);
    check("R1 per at reset", perFreq, 32'd0);
    check("R1 done at reset", {31'd0, done}, 32'd0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    // PLL off: core bypasses to the 26 MHz reference, divide by 1
    drive(32'h0000_0000, 32'h0000_0000, 32'd400000000, 1'b0);
    // low-speed reference selected, PLL used, dividers 4 and 2
    drive(32'h0000_000C, 32'h0000_1840, 32'd399000000, 1'b1);
    // mode select forces bypass despite PLL enable, max dividers
    drive(32'h0000_008C, 32'h0000_38C0, 32'd500000000, 1'b0);
    // reference select 1, PLL used, all-ones PLL frequency
    drive(32'h0000_000A, 32'h0000_38C0, 32'hFFFF_FFFF, 1'b0);
    // reference select 3, all unrelated divider bits set
    drive(32'hFFFF_FF7E, 32'hFFFF_FFFF, 32'd532000000, 1'b1);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule